// File: doc/BRIEF.md
# Grouped copy-descriptor slot queue

This block stages copy descriptors written through a simple register port and holds them in a small slot queue until an address generator consumes them. Software fills four staging registers: source address, destination address, line length and repeat count. It then writes the commit register, which copies the staged values into a free slot. Each descriptor is tagged with whichever of the two groups is currently selected for building. The staging registers are shared by both groups and are not duplicated. For that reason a group that holds committed descriptors and has not been launched blocks any commit to the other group.

Each group has its own launch register. Once a group is launched, its descriptors are presented to the address generator with a valid/ready handshake. Groups run in the order they were launched, and descriptors within a group run in the order they were committed. Each done pulse from the address generator retires the oldest issued descriptor and returns its slot. When a group's last descriptor retires, or when a group is launched with nothing committed, that group's completion flag is set. Each flag drives its own interrupt line through an independent mask bit. Four saturating counters record read and write stall cycles. Each stall cycle is charged to the group of the oldest outstanding descriptor, and the counters only advance while the stall-count enable is set.

Top module: `dmaq_slot_queue`

## Requirements
- R1: After reset the status register (address 8) reads free count = SLOTS in bits [7:0], build group bit [8] = 0, launched bits [10:9] = 0 and pending bits [12:11] = 0. The interrupt outputs, the completion flags (address 11), ag_valid and all four stall counters (addresses 12..15) read 0.
- R2: Staging registers src (0), dst (1), len (2) and reps (3) read back as written. A write with bit 0 = 1 to the commit register (4) stores them as one descriptor tagged with the build group (address 5, bit 0). The free count then drops by one on the next cycle.
- R3: A commit is ignored, leaving status unchanged, in any of these cases: the free count is 0; the build group already holds MAX_PER_GRP descriptors; the build group is launched; or the other group is pending, meaning it holds committed descriptors and is not launched.
- R4: A group's descriptors reach ag_valid, ag_src, ag_dst, ag_len, ag_reps and ag_grp only after a write with bit 0 = 1 to that group's launch register (6 for group 0, 7 for group 1). They appear in commit order, one for each ag_valid && ag_ready cycle.
- R5: Launched groups are issued in launch order. A group launched later is issued only after every descriptor of the earlier group has been issued.
- R6: Each ag_done pulse frees the oldest issued slot, and the free count rises by one on the next cycle. A commit in the same cycle as ag_done leaves the free count unchanged.
- R7: On the cycle after a group's last descriptor retires, its launched bit clears and its completion flag sets (address 11, bit = group). irq[g] equals flag[g] AND mask[g] (address 10). Writing 1 to a flag bit clears it.
- R8: Launching a group that holds no descriptors sets that group's completion flag on the next cycle and does not set its launched bit.
- R9: The stall counters are read-group-0 (12), write-group-0 (13), read-group-1 (14) and write-group-1 (15). They count cycles where the stall input is high, the enable (address 9, bit 0) is 1, and a descriptor of that group is the oldest outstanding one. They saturate at all-ones, and any write to address 9 clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| ag_valid | output | 1 | Descriptor offered to the address generator |
| ag_ready | input | 1 | Address generator accepts the descriptor |
| ag_src | output | ADDR_W | Source address of the offered descriptor |
| ag_dst | output | ADDR_W | Destination address of the offered descriptor |
| ag_len | output | LEN_W | Line length of the offered descriptor |
| ag_reps | output | REP_W | Repeat count of the offered descriptor |
| ag_grp | output | 1 | Group tag of the offered descriptor |
| ag_done | input | 1 | Oldest issued descriptor has finished |
| rd_stall | input | 1 | Read side stalled this cycle |
| wr_stall | input | 1 | Write side stalled this cycle |
| irq | output | 2 | Masked per-group completion interrupts |

## Verification
The two functions that can land in the same cycle are a commit, which takes a slot, and an ag_done retirement, which returns one. The bench drives both in the same clock cycle after a done has left exactly one slot free. It then requires that the free count reads the same as before, that the new descriptor is issued later in its proper place, and that no completion flag rises early. It also lines up a retirement of one group's last descriptor with the other group waiting to launch. The flag and the launched bits are checked on the following cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;
   localparam int NGRP = 2;

   typedef enum logic [3:0] {
      RA_SRC      = 4'd0,
      RA_DST      = 4'd1,
      RA_LEN      = 4'd2,
      RA_REP      = 4'd3,
      RA_COMMIT   = 4'd4,
      RA_BUILD    = 4'd5,
      RA_LAUNCH0  = 4'd6,
      RA_LAUNCH1  = 4'd7,
      RA_STATUS   = 4'd8,
      RA_STALLCFG = 4'd9,
      RA_IRQMASK  = 4'd10,
      RA_IRQFLAG  = 4'd11,
      RA_RSTALL0  = 4'd12,
      RA_WSTALL0  = 4'd13,
      RA_RSTALL1  = 4'd14,
      RA_WSTALL1  = 4'd15
   } reg_addr_e;
endpackage

// File: rtl/dq_slot_fifo.sv
module dq_slot_fifo #(
   parameter int DEPTH = 20,
   parameter int DW    = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             push_tag,
   input  logic             issue,
   input  logic             retire,
   output logic             iss_valid,
   output logic [DW-1:0]    iss_data,
   output logic             iss_tag,
   output logic             ret_tag,
   output logic             outstanding,
   output logic [CNT_W-1:0] free_cnt
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DW-1:0]    mem [DEPTH];
   logic [DEPTH-1:0] tag_q;
   logic [IDX_W-1:0] ptr_q   [3];
   logic [IDX_W-1:0] ptr_nxt [3];
   logic [2:0]       ptr_adv;
   logic [CNT_W-1:0] occ_q, ucnt_q;

   assign ptr_adv = {retire, issue, push};

   // pointer 0: write, 1: issue, 2: retire
   for (genvar p = 0; p < 3; p++) begin : g_ptr
      if (POW2) begin : g_wrap_free
         assign ptr_nxt[p] = ptr_q[p] + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt[p] = (ptr_q[p] == IDX_W'(DEPTH - 1)) ? '0 : ptr_q[p] + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ptr_q[p] <= '0;
         else if (ptr_adv[p]) ptr_q[p] <= ptr_nxt[p];
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[ptr_q[0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q  <= '0;
         occ_q  <= '0;
         ucnt_q <= '0;
      end else begin
         if (push) tag_q[ptr_q[0]] <= push_tag;
         if (push && !retire)      occ_q <= occ_q + 1'b1;
         else if (!push && retire) occ_q <= occ_q - 1'b1;
         if (push && !issue)       ucnt_q <= ucnt_q + 1'b1;
         else if (!push && issue)  ucnt_q <= ucnt_q - 1'b1;
      end
   end

   assign iss_valid   = (ucnt_q != '0);
   assign iss_data    = mem[ptr_q[1]];
   assign iss_tag     = tag_q[ptr_q[1]];
   assign ret_tag     = tag_q[ptr_q[2]];
   assign outstanding = (occ_q != ucnt_q);
   assign free_cnt    = CNT_W'(DEPTH) - occ_q;

   a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (occ_q < CNT_W'(DEPTH)));
   a_r4_issue_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (ucnt_q != '0));
   a_r6_retire_has_issued: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> outstanding);
   a_r6_free_step: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !push) |=> (free_cnt == CNT_W'($past(free_cnt) + 1'b1)));
   a_r6_free_balance: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && push) |=> $stable(free_cnt));
endmodule

// File: rtl/dq_grp_ctrl.sv
module dq_grp_ctrl #(
   parameter int MAXN = 20,
   localparam int CW = $clog2(MAXN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic          launch,
   input  logic          retire,
   input  logic          irq_clr,
   output logic [CW-1:0] cnt,
   output logic          launched,
   output logic          irq_pend
);
   logic empty_launch, last_retire;

   assign empty_launch = launch && !launched && (cnt == '0);
   assign last_retire  = retire && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         launched <= 1'b0;
         irq_pend <= 1'b0;
      end else begin
         if (commit && !retire)      cnt <= cnt + 1'b1;
         else if (!commit && retire) cnt <= cnt - 1'b1;
         if (last_retire)                   launched <= 1'b0;
         else if (launch && cnt != '0)      launched <= 1'b1;
         irq_pend <= (irq_pend && !irq_clr) || empty_launch || last_retire;
      end
   end

   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAXN));
   a_r3_no_commit_launched: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !launched);
   a_r8_empty_launch_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !launched && cnt == '0) |=> (irq_pend && !launched));
   a_r7_last_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && cnt == CW'(1)) |=> (irq_pend && !launched));
endmodule

// File: rtl/dq_sat_ctr.sv
module dq_sat_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clr)                cnt <= '0;
      else if (inc && !(&cnt))     cnt <= cnt + 1'b1;
   end

   a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      ((&cnt) && !clr) |=> (&cnt));
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/dmaq_slot_queue.sv
module dmaq_slot_queue
   import dq_pkg::*;
#(
   parameter int SLOTS       = 20,
   parameter int MAX_PER_GRP = 20,
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int REP_W       = 14,
   parameter int STALL_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ag_valid,
   input  logic              ag_ready,
   output logic [ADDR_W-1:0] ag_src,
   output logic [ADDR_W-1:0] ag_dst,
   output logic [LEN_W-1:0]  ag_len,
   output logic [REP_W-1:0]  ag_reps,
   output logic              ag_grp,
   input  logic              ag_done,
   input  logic              rd_stall,
   input  logic              wr_stall,
   output logic [1:0]        irq
);
   localparam int DW    = 2 * ADDR_W + LEN_W + REP_W;
   localparam int CNT_W = $clog2(SLOTS + 1);
   localparam int GCW   = $clog2(MAX_PER_GRP + 1);

   if (SLOTS < 2 || SLOTS > 255) begin : g_bad_slots
      $error("SLOTS must lie in 2..255");
   end
   if (MAX_PER_GRP < 1 || MAX_PER_GRP > SLOTS) begin : g_bad_max
      $error("MAX_PER_GRP must lie in 1..SLOTS");
   end
   if (ADDR_W > 32 || LEN_W > 32 || REP_W > 32 || STALL_W > 32 || STALL_W < 2) begin : g_bad_w
      $error("field widths must not exceed the 32-bit register port");
   end

   logic [ADDR_W-1:0] stg_src, stg_dst;
   logic [LEN_W-1:0]  stg_len;
   logic [REP_W-1:0]  stg_rep;
   logic              build_sel, stall_en;
   logic [1:0]        irq_mask;

   logic [CNT_W-1:0]  free_cnt;
   logic              iss_valid, iss_tag, ret_tag, outstanding;
   logic [DW-1:0]     iss_data;

   logic [GCW-1:0]    grp_cnt  [NGRP];
   logic [NGRP-1:0]   grp_launched, grp_pending, grp_flag;
   logic [NGRP-1:0]   grp_commit, grp_launch, grp_retire, grp_clr;
   logic [STALL_W-1:0] stall_cnt [NGRP][2];

   logic commit_req, commit_ok, issue, stall_clr;

   function automatic logic wr_at(input logic [3:0] a, input reg_addr_e r);
      return (a == r);
   endfunction

   // staging and control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_src   <= '0;
         stg_dst   <= '0;
         stg_len   <= '0;
         stg_rep   <= '0;
         build_sel <= 1'b0;
         stall_en  <= 1'b0;
         irq_mask  <= '0;
      end else if (reg_wr) begin
         if (wr_at(reg_addr, RA_SRC))      stg_src   <= reg_wdata[ADDR_W-1:0];
         if (wr_at(reg_addr, RA_DST))      stg_dst   <= reg_wdata[ADDR_W-1:0];
         if (wr_at(reg_addr, RA_LEN))      stg_len   <= reg_wdata[LEN_W-1:0];
         if (wr_at(reg_addr, RA_REP))      stg_rep   <= reg_wdata[REP_W-1:0];
         if (wr_at(reg_addr, RA_BUILD))    build_sel <= reg_wdata[0];
         if (wr_at(reg_addr, RA_STALLCFG)) stall_en  <= reg_wdata[0];
         if (wr_at(reg_addr, RA_IRQMASK))  irq_mask  <= reg_wdata[1:0];
      end
   end

   assign commit_req = reg_wr && wr_at(reg_addr, RA_COMMIT) && reg_wdata[0];
   assign commit_ok  = commit_req
                     && (free_cnt != '0)
                     && (grp_cnt[build_sel] != GCW'(MAX_PER_GRP))
                     && !grp_launched[build_sel]
                     && !grp_pending[!build_sel];
   assign stall_clr  = reg_wr && wr_at(reg_addr, RA_STALLCFG);

   dq_slot_fifo #(.DEPTH(SLOTS), .DW(DW)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (commit_ok),
      .push_data   ({stg_src, stg_dst, stg_len, stg_rep}),
      .push_tag    (build_sel),
      .issue       (issue),
      .retire      (ag_done),
      .iss_valid   (iss_valid),
      .iss_data    (iss_data),
      .iss_tag     (iss_tag),
      .ret_tag     (ret_tag),
      .outstanding (outstanding),
      .free_cnt    (free_cnt)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_commit[g] = commit_ok && (build_sel == 1'(g));
      assign grp_launch[g] = reg_wr && reg_wdata[0]
                           && wr_at(reg_addr, (g == 0) ? RA_LAUNCH0 : RA_LAUNCH1);
      assign grp_retire[g] = ag_done && (ret_tag == 1'(g));
      assign grp_clr[g]    = reg_wr && wr_at(reg_addr, RA_IRQFLAG) && reg_wdata[g];
      assign grp_pending[g] = (grp_cnt[g] != '0) && !grp_launched[g];

      dq_grp_ctrl #(.MAXN(MAX_PER_GRP)) u_ctrl (
         .clk      (clk),
         .rst_n    (rst_n),
         .commit   (grp_commit[g]),
         .launch   (grp_launch[g]),
         .retire   (grp_retire[g]),
         .irq_clr  (grp_clr[g]),
         .cnt      (grp_cnt[g]),
         .launched (grp_launched[g]),
         .irq_pend (grp_flag[g])
      );

      for (genvar k = 0; k < 2; k++) begin : g_stall
         logic hit;
         assign hit = stall_en && outstanding && (ret_tag == 1'(g))
                    && ((k == 0) ? rd_stall : wr_stall);
         dq_sat_ctr #(.W(STALL_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (stall_clr),
            .inc   (hit),
            .cnt   (stall_cnt[g][k])
         );
      end
   end

   // issue side
   assign ag_valid = iss_valid && grp_launched[iss_tag];
   assign issue    = ag_valid && ag_ready;
   assign {ag_src, ag_dst, ag_len, ag_reps} = iss_data;
   assign ag_grp   = iss_tag;
   assign irq      = grp_flag & irq_mask;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_SRC:      reg_rdata = 32'(stg_src);
         RA_DST:      reg_rdata = 32'(stg_dst);
         RA_LEN:      reg_rdata = 32'(stg_len);
         RA_REP:      reg_rdata = 32'(stg_rep);
         RA_BUILD:    reg_rdata = {31'd0, build_sel};
         RA_STATUS:   reg_rdata = {19'd0, grp_pending, grp_launched, build_sel, 8'(free_cnt)};
         RA_STALLCFG: reg_rdata = {31'd0, stall_en};
         RA_IRQMASK:  reg_rdata = {30'd0, irq_mask};
         RA_IRQFLAG:  reg_rdata = {30'd0, grp_flag};
         RA_RSTALL0:  reg_rdata = 32'(stall_cnt[0][0]);
         RA_WSTALL0:  reg_rdata = 32'(stall_cnt[0][1]);
         RA_RSTALL1:  reg_rdata = 32'(stall_cnt[1][0]);
         RA_WSTALL1:  reg_rdata = 32'(stall_cnt[1][1]);
         default:     reg_rdata = '0;
      endcase
   end

   a_r2_commit_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ok && !ag_done) |=> (free_cnt == CNT_W'($past(free_cnt) - 1'b1)));
   a_r3_reject_keeps_free: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && !commit_ok && !ag_done) |=> $stable(free_cnt));
   a_r5_one_group_offered: assert property (@(posedge clk) disable iff (!rst_n)
      (ag_valid && outstanding) |-> (ag_grp == ret_tag || grp_launched[ret_tag]));
   a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq) || (irq_mask == 2'b11));
endmodule

// File: tb/dmaq_slot_queue_tb_top.sv
`timescale 1ns/1ps
module dmaq_slot_queue_tb_top;
   localparam int SLOTS = 4;
   localparam int MAXG  = 3;
   localparam int SW    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ag_valid, ag_grp;
   logic        ag_ready = 1'b0, ag_done = 1'b0, rd_stall = 1'b0, wr_stall = 1'b0;
   logic [31:0] ag_src, ag_dst;
   logic [15:0] ag_len;
   logic [13:0] ag_reps;
   logic [1:0]  irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dmaq_slot_queue #(.SLOTS(SLOTS), .MAX_PER_GRP(MAXG), .STALL_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ag_valid(ag_valid),
      .ag_ready(ag_ready), .ag_src(ag_src), .ag_dst(ag_dst), .ag_len(ag_len),
      .ag_reps(ag_reps), .ag_grp(ag_grp), .ag_done(ag_done),
      .rd_stall(rd_stall), .wr_stall(wr_stall), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      reg_addr = a;
      #0.5;
      v = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   // status word built from the R1 field layout
   function automatic logic [31:0] st(input int free, input int bsel, input int l0,
                                      input int l1, input int p0, input int p1);
      return 32'(free) | (32'(bsel) << 8) | (32'(l0) << 9) | (32'(l1) << 10)
           | (32'(p0) << 11) | (32'(p1) << 12);
   endfunction

   task automatic stage(input int id);
      wr(4'd0, 32'h1000 + 32'(id));
      wr(4'd1, 32'h2000 + 32'(id));
      wr(4'd2, 32'h40 + 32'(id));
      wr(4'd3, 32'(id + 1));
   endtask

   task automatic take(input string req, input int id, input logic grp);
      #0.5;
      chk({req, " valid"}, 32'(ag_valid), 32'd1);
      chk({req, " src"},   ag_src, 32'h1000 + 32'(id));
      chk({req, " dst"},   ag_dst, 32'h2000 + 32'(id));
      chk({req, " len"},   32'(ag_len), 32'h40 + 32'(id));
      chk({req, " reps"},  32'(ag_reps), 32'(id + 1));
      chk({req, " grp"},   32'(ag_grp), 32'(grp));
      @(negedge clk); ag_ready = 1'b1;
      @(negedge clk); ag_ready = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk); ag_done = 1'b1;
      @(negedge clk); ag_done = 1'b0;
   endtask

   task automatic stall(input logic r, input logic w, input int n);
      @(negedge clk); rd_stall = r; wr_stall = w;
      repeat (n) @(negedge clk);
      rd_stall = 1'b0; wr_stall = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_reg("R1 status", 4'd8, st(SLOTS, 0, 0, 0, 0, 0));
      chk_reg("R1 flags", 4'd11, 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 ag_valid", 32'(ag_valid), 32'd0);
      for (int a = 12; a < 16; a++) chk_reg("R1 stall ctr", 4'(a), 32'd0);

      // R2 staging readback and commits into group 0
      for (int i = 0; i < MAXG; i++) begin
         stage(i);
         if (i == 0) begin
            chk_reg("R2 src readback", 4'd0, 32'h1000);
            chk_reg("R2 len readback", 4'd2, 32'h40);
         end
         wr(4'd4, 32'd1);
         chk_reg("R2 free after commit", 4'd8, st(SLOTS - i - 1, 0, 0, 0, 1, 0));
      end
      // R3 per-group limit
      stage(9);
      wr(4'd4, 32'd1);
      chk_reg("R3 group full", 4'd8, st(1, 0, 0, 0, 1, 0));
      // R3 other group pending
      wr(4'd5, 32'd1);
      wr(4'd4, 32'd1);
      chk_reg("R3 other pending", 4'd8, st(1, 1, 0, 0, 1, 0));
      // R4 nothing offered before launch
      #0.5 chk("R4 no valid before launch", 32'(ag_valid), 32'd0);
      wr(4'd6, 32'd1);
      chk_reg("R4 launched0", 4'd8, st(1, 1, 1, 0, 0, 0));
      for (int i = 0; i < MAXG; i++) take("R4 order", i, 1'b0);
      #0.5 chk("R4 drained", 32'(ag_valid), 32'd0);

      // group 1 built while group 0 runs
      stage(16);
      wr(4'd4, 32'd1);
      chk_reg("R2 commit g1", 4'd8, st(0, 1, 1, 0, 0, 1));
      stage(17);
      wr(4'd4, 32'd1);
      chk_reg("R3 free zero", 4'd8, st(0, 1, 1, 0, 0, 1));
      // R3 commit into a launched group
      wr(4'd5, 32'd0);
      wr(4'd4, 32'd1);
      chk_reg("R3 target launched", 4'd8, st(0, 0, 1, 0, 0, 1));
      wr(4'd5, 32'd1);
      done_pulse();
      chk_reg("R6 free after done", 4'd8, st(1, 1, 1, 0, 0, 1));
      // R6 commit and done in the same cycle
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1; ag_done = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ag_done = 1'b0;
      chk_reg("R6 same cycle free", 4'd8, st(1, 1, 1, 0, 0, 1));
      chk_reg("R7 no early flag", 4'd11, 32'd0);

      // R5 group 1 after group 0
      wr(4'd7, 32'd1);
      chk_reg("R5 both launched", 4'd8, st(1, 1, 1, 1, 0, 0));
      take("R5 g1 first", 16, 1'b1);
      take("R5 g1 second", 17, 1'b1);

      // R7 completion flags and masking
      wr(4'd10, 32'd1);
      done_pulse();
      chk_reg("R7 g0 flag", 4'd11, 32'd1);
      chk("R7 irq g0", 32'(irq), 32'd1);
      chk_reg("R7 launched0 clear", 4'd8, st(2, 1, 0, 1, 0, 0));
      done_pulse();
      chk_reg("R7 g1 not last", 4'd11, 32'd1);
      done_pulse();
      chk_reg("R7 both flags", 4'd11, 32'd3);
      chk("R7 mask g0 only", 32'(irq), 32'd1);
      wr(4'd10, 32'd2);
      chk("R7 mask g1 only", 32'(irq), 32'd2);
      wr(4'd11, 32'd1);
      chk_reg("R7 w1c g0", 4'd11, 32'd2);
      wr(4'd11, 32'd2);
      chk_reg("R7 w1c g1", 4'd11, 32'd0);
      chk_reg("R7 all free", 4'd8, st(SLOTS, 1, 0, 0, 0, 0));

      // R8 empty launch
      wr(4'd7, 32'd1);
      chk_reg("R8 empty flag", 4'd11, 32'd2);
      chk_reg("R8 not launched", 4'd8, st(SLOTS, 1, 0, 0, 0, 0));
      wr(4'd11, 32'd3);

      // R9 stall counters
      wr(4'd5, 32'd0);
      stage(5);
      wr(4'd4, 32'd1);
      wr(4'd6, 32'd1);
      take("R9 setup", 5, 1'b0);
      stall(1'b1, 1'b0, 3);
      chk_reg("R9 disabled", 4'd12, 32'd0);
      wr(4'd9, 32'd1);
      stall(1'b1, 1'b0, 5);
      chk_reg("R9 read g0", 4'd12, 32'd5);
      stall(1'b0, 1'b1, 2);
      chk_reg("R9 write g0", 4'd13, 32'd2);
      chk_reg("R9 read g1 idle", 4'd14, 32'd0);
      stall(1'b1, 1'b1, 20);
      chk_reg("R9 saturate", 4'd12, 32'((1 << SW) - 1));
      wr(4'd9, 32'd1);
      chk_reg("R9 cleared", 4'd12, 32'd0);
      done_pulse();
      stall(1'b1, 1'b0, 3);
      chk_reg("R9 no outstanding", 4'd12, 32'd0);

      summary();
   end
endmodule